// File: doc/BRIEF.md
# Two-Thread Alternating Retirement Arbiter

This block is the in-order commit stage of a core that runs two hardware threads. It keeps one circular reorder ring per thread. The front end asks each ring for a slot and gets back an entry tag. Execution units later report completion by tag, in any order. Each cycle the arbiter retires up to three completed micro-ops. They all come from one thread. Within that thread they are the longest run of completed entries starting at the oldest one. The arbiter alternates between the threads so that the retirement bandwidth is shared.

A small turn state machine decides which thread has priority. It has two states, `TURN_T0` and `TURN_T1`. After a cycle in which thread X commits, the state moves to the turn of the other thread. In a cycle with no commit the state holds. If the thread whose turn it is has nothing ready at its head, the cycle goes to the other thread, so a stalled thread never wastes a commit slot.

Each thread can be flushed on its own. In dual mode each thread may hold at most half of the total entries. In single-thread mode thread 0 may hold every entry and thread 1 is shut out.

Top module: `retire_arbiter`

## Requirements
- R1: A commit cycle asserts `commit_valid` with `commit_cnt` between 1 and 3, and no other cycle asserts it.
- R2: When both threads have a completed head entry, successive commit cycles alternate between the threads. After a commit by thread X, the next commit cycle prefers the other thread.
- R3: In dual mode an allocation request is granted only while that thread holds fewer than DEPTH/2 entries. A request beyond that gets `alloc_gnt` low.
- R4: Commit is in program order. The arbiter retires the longest run of completed entries starting at the thread's oldest entry, capped at three. An entry that completes ahead of an older incomplete one is held back until the older one completes.
- R5: In the cycle that `flushN` is high, thread N commits nothing and is granted no allocation. From the next cycle thread N is empty and its next allocated tag has index 0.
- R6: If the thread whose turn it is has no completed head and the other thread has one, the other thread commits in that same cycle.
- R7: A writeback whose tag does not name a live entry has no effect on later commits.
- R8: With `solo_mode` high, thread 0 may hold all DEPTH entries and thread 1 is never granted. Thread 0 commits in every cycle in which its head is complete.
- R9: A tag has the thread id in its most significant bit and the ring index in its low bits. Index values start at 0 after reset and increase by one per grant, modulo DEPTH.
- R10: After reset there is no commit, and the offered tags are index 0 for thread 0 (value 0) and for thread 1 (value DEPTH).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| solo_mode | input | 1 | Single-thread mode, thread 0 only |
| alloc_req0 | input | 1 | Thread 0 asks for a reorder entry |
| alloc_gnt0 | output | 1 | Thread 0 request accepted this cycle |
| alloc_tag0 | output | TW | Tag that thread 0 receives on a grant |
| alloc_req1 | input | 1 | Thread 1 asks for a reorder entry |
| alloc_gnt1 | output | 1 | Thread 1 request accepted this cycle |
| alloc_tag1 | output | TW | Tag that thread 1 receives on a grant |
| wb_valid | input | 1 | A completion is reported this cycle |
| wb_tag | input | TW | Tag of the completed micro-op |
| flush0 | input | 1 | Discard all of thread 0's entries |
| flush1 | input | 1 | Discard all of thread 1's entries |
| commit_valid | output | 1 | One or more entries retire this cycle |
| commit_tid | output | 1 | Thread that retires |
| commit_cnt | output | RCW | Number retiring, 1 to 3 |
| commit_tags | output | 3*TW | Retiring tags, oldest in lane 0 |

## Verification
Grants and offered tags are combinational on the request, so the bench reads them one time unit after it drives the request, inside the same cycle. A completion written at one clock edge makes its entry eligible in the following cycle. Commit outputs are combinational from the state, so the bench pushes the expected commit into the scoreboard when it drives the enabling writeback, and the monitor pops it one cycle later. The monitor samples two time units after the falling edge, after the driver has settled. A flush takes effect in its own cycle: the monitor checks that the flush cycle shows no commit for that thread, and the very next grant checks the pointer reset.

// File: rtl/retire_pkg.sv
package retire_pkg;
    typedef enum logic {
        TURN_T0 = 1'b0,
        TURN_T1 = 1'b1
    } turn_e;
endpackage

// File: rtl/rob_thread_ring.sv
module rob_thread_ring #(
    parameter int DEPTH = 32,
    parameter int RET   = 3,
    parameter int IW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1),
    parameter int RCW   = $clog2(RET + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CW-1:0]     cap,
    input  logic              alloc_req,
    output logic              alloc_gnt,
    output logic [IW-1:0]     tail_idx,
    input  logic              wb_hit,
    input  logic [IW-1:0]     wb_idx,
    input  logic              flush,
    input  logic [RCW-1:0]    retire_cnt,
    output logic [RCW-1:0]    run_len,
    output logic [RET*IW-1:0] head_win
);
    logic [DEPTH-1:0] live;
    logic [DEPTH-1:0] done;
    logic [IW-1:0]    head;
    logic [IW-1:0]    tail;
    logic [CW-1:0]    count;

    assign alloc_gnt = alloc_req && !flush && (count < cap);
    assign tail_idx  = tail;

    for (genvar k = 0; k < RET; k++) begin : g_win
        assign head_win[k*IW +: IW] = head + IW'(k);
    end

    always_comb begin
        logic stop;
        stop    = 1'b0;
        run_len = '0;
        for (int k = 0; k < RET; k++) begin
            if (!stop && live[head + IW'(k)] && done[head + IW'(k)])
                run_len = RCW'(k + 1);
            else
                stop = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            live  <= '0;
            done  <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (wb_hit && live[wb_idx])
                done[wb_idx] <= 1'b1;
            if (alloc_gnt) begin
                live[tail] <= 1'b1;
                done[tail] <= 1'b0;
                tail       <= tail + 1'b1;
            end
            for (int k = 0; k < RET; k++) begin
                if (k < int'(retire_cnt)) begin
                    live[head + IW'(k)] <= 1'b0;
                    done[head + IW'(k)] <= 1'b0;
                end
            end
            head  <= head + IW'(retire_cnt);
            count <= count + CW'(alloc_gnt) - CW'(retire_cnt);
        end
    end

    // R3: a grant never takes a thread past its capacity
    p_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(alloc_gnt) && !$past(flush) |-> count <= $past(cap));

    // R4: retirement never outruns the completed run at the head
    p_ready_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
        retire_cnt <= run_len);

    // R5: the cycle after a flush finds the ring empty with reset pointers
    p_flush_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(flush) |-> (count == '0 && head == '0 && tail == '0));
endmodule

// File: rtl/retire_select.sv
module retire_select
    import retire_pkg::*;
#(
    parameter int RET = 3,
    parameter int RCW = $clog2(RET + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           solo,
    input  logic           flush0,
    input  logic           flush1,
    input  logic [RCW-1:0] run0,
    input  logic [RCW-1:0] run1,
    output logic           commit_valid,
    output logic           commit_tid,
    output logic [RCW-1:0] commit_cnt,
    output logic [RCW-1:0] ret0,
    output logic [RCW-1:0] ret1
);
    turn_e state, state_nxt;
    logic  elig0, elig1;

    assign elig0 = (run0 != '0) && !flush0;
    assign elig1 = (run1 != '0) && !flush1 && !solo;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= TURN_T0;
        else        state <= state_nxt;
    end

    always_comb begin
        commit_valid = 1'b0;
        commit_tid   = 1'b0;
        unique case (state)
            TURN_T0: begin
                if (elig0)      begin commit_valid = 1'b1; commit_tid = 1'b0; end
                else if (elig1) begin commit_valid = 1'b1; commit_tid = 1'b1; end
            end
            TURN_T1: begin
                if (elig1)      begin commit_valid = 1'b1; commit_tid = 1'b1; end
                else if (elig0) begin commit_valid = 1'b1; commit_tid = 1'b0; end
            end
            default: ;
        endcase
        commit_cnt = !commit_valid ? '0 : (commit_tid ? run1 : run0);
        ret0       = (commit_valid && !commit_tid) ? commit_cnt : '0;
        ret1       = (commit_valid &&  commit_tid) ? commit_cnt : '0;
        state_nxt  = state;
        if (commit_valid)
            state_nxt = commit_tid ? TURN_T0 : TURN_T1;
    end

    // R1: a commit always carries between one and RET entries
    p_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
        commit_valid |-> (commit_cnt != '0 && commit_cnt <= RCW'(RET)));

    // R2: with both threads ready, consecutive commits swap thread
    p_alternate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (elig0 && elig1 && $past(commit_valid)) |-> commit_tid != $past(commit_tid));

    // R6: a ready thread is never left idle
    p_no_waste_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (elig0 || elig1) |-> commit_valid);
endmodule

// File: rtl/retire_arbiter.sv
module retire_arbiter #(
    parameter int DEPTH = 32,
    parameter int RET   = 3,
    parameter int TW    = $clog2(DEPTH) + 1,
    parameter int RCW   = $clog2(RET + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              solo_mode,
    input  logic              alloc_req0,
    output logic              alloc_gnt0,
    output logic [TW-1:0]     alloc_tag0,
    input  logic              alloc_req1,
    output logic              alloc_gnt1,
    output logic [TW-1:0]     alloc_tag1,
    input  logic              wb_valid,
    input  logic [TW-1:0]     wb_tag,
    input  logic              flush0,
    input  logic              flush1,
    output logic              commit_valid,
    output logic              commit_tid,
    output logic [RCW-1:0]    commit_cnt,
    output logic [RET*TW-1:0] commit_tags
);
    localparam int IW   = TW - 1;
    localparam int CW   = $clog2(DEPTH + 1);
    localparam int HALF = DEPTH / 2;

    logic [CW-1:0]     cap_v   [2];
    logic              req_v   [2];
    logic              gnt_v   [2];
    logic [IW-1:0]     tail_v  [2];
    logic              flush_v [2];
    logic [RCW-1:0]    ret_v   [2];
    logic [RCW-1:0]    run_v   [2];
    logic [RET*IW-1:0] win_v   [2];

    assign cap_v[0]   = solo_mode ? CW'(DEPTH) : CW'(HALF);
    assign cap_v[1]   = solo_mode ? '0 : CW'(HALF);
    assign req_v[0]   = alloc_req0;
    assign req_v[1]   = alloc_req1;
    assign flush_v[0] = flush0;
    assign flush_v[1] = flush1;

    for (genvar t = 0; t < 2; t++) begin : g_ring
        rob_thread_ring #(.DEPTH(DEPTH), .RET(RET), .IW(IW), .CW(CW), .RCW(RCW)) u_ring (
            .clk       (clk),
            .rst_n     (rst_n),
            .cap       (cap_v[t]),
            .alloc_req (req_v[t]),
            .alloc_gnt (gnt_v[t]),
            .tail_idx  (tail_v[t]),
            .wb_hit    (wb_valid && (wb_tag[TW-1] == 1'(t))),
            .wb_idx    (wb_tag[IW-1:0]),
            .flush     (flush_v[t]),
            .retire_cnt(ret_v[t]),
            .run_len   (run_v[t]),
            .head_win  (win_v[t])
        );
    end

    retire_select #(.RET(RET), .RCW(RCW)) u_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .solo        (solo_mode),
        .flush0      (flush0),
        .flush1      (flush1),
        .run0        (run_v[0]),
        .run1        (run_v[1]),
        .commit_valid(commit_valid),
        .commit_tid  (commit_tid),
        .commit_cnt  (commit_cnt),
        .ret0        (ret_v[0]),
        .ret1        (ret_v[1])
    );

    assign alloc_gnt0 = gnt_v[0];
    assign alloc_gnt1 = gnt_v[1];
    assign alloc_tag0 = {1'b0, tail_v[0]};
    assign alloc_tag1 = {1'b1, tail_v[1]};

    for (genvar k = 0; k < RET; k++) begin : g_lane
        assign commit_tags[k*TW +: TW] =
            {commit_tid, commit_tid ? win_v[1][k*IW +: IW] : win_v[0][k*IW +: IW]};
    end

    // R5: a thread under flush neither commits nor allocates
    p_flush_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flush0 |-> !(commit_valid && !commit_tid) && !alloc_gnt0) and
        (flush1 |-> !(commit_valid &&  commit_tid) && !alloc_gnt1));

    // R8: single-thread mode shuts thread 1 out of allocation and commit
    p_solo_r8: assert property (@(posedge clk) disable iff (!rst_n)
        solo_mode |-> !alloc_gnt1 && !(commit_valid && commit_tid));
endmodule

// File: tb/sim_retire_arbiter.sv
module sim_retire_arbiter;
    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 32;
    localparam int RET   = 3;
    localparam int TW    = 6;
    localparam int RCW   = 2;

    logic clk = 0, rst_n = 0, solo_mode = 0;
    logic alloc_req0 = 0, alloc_req1 = 0, wb_valid = 0, flush0 = 0, flush1 = 0;
    logic [TW-1:0] wb_tag = '0;
    logic alloc_gnt0, alloc_gnt1, commit_valid, commit_tid;
    logic [TW-1:0] alloc_tag0, alloc_tag1;
    logic [RCW-1:0] commit_cnt;
    logic [RET*TW-1:0] commit_tags;

    int checks = 0, fails = 0;
    bit finished = 0;

    typedef struct { int tid; int cnt; int tags[3]; string req; } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    retire_arbiter #(.DEPTH(DEPTH), .RET(RET)) u0 (
        .clk(clk), .rst_n(rst_n), .solo_mode(solo_mode),
        .alloc_req0(alloc_req0), .alloc_gnt0(alloc_gnt0), .alloc_tag0(alloc_tag0),
        .alloc_req1(alloc_req1), .alloc_gnt1(alloc_gnt1), .alloc_tag1(alloc_tag1),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .flush0(flush0), .flush1(flush1),
        .commit_valid(commit_valid), .commit_tid(commit_tid),
        .commit_cnt(commit_cnt), .commit_tags(commit_tags));

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_commit(int tid, int cnt, int t0, int t1, int t2, string req);
        exp_t e;
        e.tid = tid; e.cnt = cnt; e.tags[0] = t0; e.tags[1] = t1; e.tags[2] = t2; e.req = req;
        sb.push_back(e);
    endtask

    task automatic step(bit a0, bit a1, bit wv, int wt, bit f0, bit f1);
        @(negedge clk);
        alloc_req0 = a0; alloc_req1 = a1; wb_valid = wv; wb_tag = TW'(wt);
        flush0 = f0; flush1 = f1;
        #1;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0);
    endtask

    task automatic wb(int tag);
        step(0, 0, 1, tag, 0, 0);
    endtask

    task automatic alloc(int t, bit exp_g, int exp_tag, string req);
        step(t == 0, t == 1, 0, 0, 0, 0);
        if (t == 0) begin
            chk(alloc_gnt0 == exp_g, req, alloc_gnt0, exp_g);
            if (exp_g) chk(alloc_tag0 == TW'(exp_tag), req, alloc_tag0, exp_tag);
        end else begin
            chk(alloc_gnt1 == exp_g, req, alloc_gnt1, exp_g);
            if (exp_g) chk(alloc_tag1 == TW'(exp_tag), req, alloc_tag1, exp_tag);
        end
    endtask

    // scoreboard monitor
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (rst_n && commit_valid) begin
                if (sb.size() == 0) begin
                    chk(0, "R4 unexpected commit", int'(commit_cnt), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    chk(commit_tid == 1'(e.tid), {e.req, " tid"}, commit_tid, e.tid);
                    chk(commit_cnt == RCW'(e.cnt), {e.req, " cnt"}, commit_cnt, e.cnt);
                    for (int k = 0; k < 3; k++)
                        if (k < e.cnt)
                            chk(commit_tags[k*TW +: TW] == TW'(e.tags[k]), {e.req, " tag"},
                                commit_tags[k*TW +: TW], e.tags[k]);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            fails++;
            $display("[TB] FAIL watchdog actual=1 expected=0");
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        #2;
        // R10: reset state
        chk(commit_valid == 0, "R10 commit after reset", commit_valid, 0);
        chk(alloc_tag0 == 0, "R10 tag0", alloc_tag0, 0);
        chk(alloc_tag1 == TW'(DEPTH), "R10 tag1", alloc_tag1, DEPTH);

        // R4: out-of-order completion held back at the head
        for (int i = 0; i < 5; i++) alloc(0, 1, i, "R9 seq tag t0");
        wb(2); wb(1); idle(2);
        expect_commit(0, 3, 0, 1, 2, "R4 run of three");
        wb(0); idle(1);
        wb(4); idle(1);
        expect_commit(0, 2, 3, 4, 0, "R4 run of two");
        wb(3); idle(2);

        // R2 / R6: both threads backlog, alternate
        for (int i = 0; i < 6; i++) begin
            step(1, 1, 0, 0, 0, 0);
            chk(alloc_tag0 == TW'(5 + i) && alloc_gnt0, "R9 dual t0", alloc_tag0, 5 + i);
            chk(alloc_tag1 == TW'(32 + i) && alloc_gnt1, "R9 dual t1", alloc_tag1, 32 + i);
        end
        for (int i = 6; i <= 10; i++) wb(i);
        for (int i = 33; i <= 37; i++) wb(i);
        idle(1);
        expect_commit(0, 3, 5, 6, 7, "R6 turn given to ready thread");
        expect_commit(1, 3, 32, 33, 34, "R2 alternate to t1");
        expect_commit(0, 3, 8, 9, 10, "R2 alternate to t0");
        expect_commit(1, 3, 35, 36, 37, "R2 alternate to t1 again");
        wb(5); wb(32); idle(5);

        // R7: writeback to a dead tag is ignored
        wb(12); idle(1);
        alloc(0, 1, 11, "R9 tag 11");
        alloc(0, 1, 12, "R9 tag 12");
        expect_commit(0, 1, 11, 0, 0, "R7 dead writeback ignored");
        wb(11); idle(1);
        expect_commit(0, 1, 12, 0, 0, "R7 later commit");
        wb(12); idle(2);

        // R3: half capacity; R5: flush
        for (int i = 0; i < 16; i++) alloc(1, 1, 38 + i, "R3 within half");
        alloc(1, 0, 0, "R3 over half refused");
        wb(38);
        step(0, 1, 0, 0, 0, 1);
        chk(alloc_gnt1 == 0, "R5 no grant in flush cycle", alloc_gnt1, 0);
        step(0, 1, 1, 39, 0, 0);
        chk(alloc_gnt1 == 1 && alloc_tag1 == TW'(32), "R5 pointer reset", alloc_tag1, 32);
        idle(2);
        expect_commit(1, 1, 32, 0, 0, "R5 post-flush commit");
        wb(32); idle(2);

        // R4: long run capped at three; R6 repeated same thread
        for (int i = 13; i <= 19; i++) alloc(0, 1, i, "R9 tag t0");
        for (int i = 14; i <= 19; i++) wb(i);
        expect_commit(0, 3, 13, 14, 15, "R4 cap three");
        expect_commit(0, 3, 16, 17, 18, "R6 same thread again");
        expect_commit(0, 1, 19, 0, 0, "R4 tail of run");
        wb(13); idle(4);

        // R8: single-thread mode
        @(negedge clk); solo_mode = 1;
        for (int i = 0; i < DEPTH; i++) alloc(0, 1, (20 + i) % DEPTH, "R8 solo fill");
        alloc(0, 0, 0, "R8 solo full refused");
        alloc(1, 0, 0, "R8 t1 shut out");
        for (int i = 0; i < DEPTH; i++) begin
            expect_commit(0, 1, (20 + i) % DEPTH, 0, 0, "R8 commit every cycle");
            wb((20 + i) % DEPTH);
        end
        idle(3);
        @(negedge clk); solo_mode = 0;
        idle(2);

        chk(sb.size() == 0, "R1 missing commits", sb.size(), 0);
        finished = 1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end
endmodule